// File: doc/BRIEF.md
# Unlock-Key Register Write Guard

This block keeps a group of sensitive configuration registers safe from stray writes. It watches the write side of a simple memory-mapped register bus. One address in the map is a write-only key register. Storing the correct 32-bit magic value there opens a write window for a protected address range. While the window is open, the block raises a write-permit signal for each bus write that lands inside that range. The protected registers use this signal as their write enable.

The window closes in two ways. Any other value written to the key register closes it on the next clock. It also closes by itself when the protected range sees no writes for a set number of timeout ticks. The ticks come from a slow timebase. The system delivers them as single-cycle enable pulses that are already in the bus clock domain. Every write into the protected range restarts the count.

The protected registers and any read path are outside this block.

Top module: `key_write_guard`

## Requirements
- R1: After reset, `unlocked` is 0 and `wr_permit` is 0.
- R2: A bus write to the key address (default 0x00C) with data exactly 0xC5AF6927 sets `unlocked` to 1 from the next clock.
- R3: A bus write to the key address with any other data, including 0 or the magic value with one bit flipped, sets `unlocked` to 0 from the next clock, whatever the previous state.
- R4: While unlocked, 32 `idle_tick` pulses with no write into the protected range clear `unlocked` on the clock of the 32nd pulse. After 31 such pulses the block is still unlocked.
- R5: A write into the protected range while unlocked restarts the idle count. This holds even when the write arrives in the same cycle as a tick; a further 31 ticks then still leave the block unlocked.
- R6: Cycles without an `idle_tick` pulse do not advance the idle count. Writes to addresses outside both the key address and the protected range do not restart it.
- R7: `wr_permit` is 1 in exactly those cycles where `bus_we` is 1, `bus_addr` lies within the inclusive range 0x800 to 0x814, and the block is unlocked. This is a combinational output.
- R8: A write into the protected range while locked gets `wr_permit` = 0 and leaves the block locked.
- R9: Writing the magic key again while unlocked keeps the block unlocked and restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| idle_tick | input | 1 | Single-cycle timeout timebase enable |
| unlocked | output | 1 | Write window open |
| wr_permit | output | 1 | Write enable for the protected range |

## Verification
The bench probes the edges of the timeout. It checks that 31 ticks keep the window open and that the 32nd closes it. A counter that is off by one would close the window one tick early or one tick late. It also sends a protected write in the same cycle as a tick; a design that lets the tick win would relock too soon. The bench tests near-miss keys, such as zero or the magic value with its top bit flipped, and range boundary addresses just inside and just outside the range. A loose key compare would open the window. A wrong range compare would pass a write one word outside the range or block the end words.

// File: rtl/key_write_guard.sv
module key_write_guard #(
  parameter int          AW         = 12,
  parameter int          DW         = 32,
  parameter logic [AW-1:0] KEY_ADDR = 12'h00C,
  parameter logic [AW-1:0] PROT_LO  = 12'h800,
  parameter logic [AW-1:0] PROT_HI  = 12'h814,
  parameter logic [DW-1:0] MAGIC    = 32'hC5AF6927,
  parameter int          IDLE_TICKS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          idle_tick,
  output logic          unlocked,
  output logic          wr_permit
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

  logic [CW-1:0] idle_cnt;
  logic          key_wr, in_prot, prot_wr;

  assign key_wr    = bus_we && (bus_addr == KEY_ADDR);
  assign in_prot   = (bus_addr >= PROT_LO) && (bus_addr <= PROT_HI);
  assign prot_wr   = bus_we && in_prot;
  assign wr_permit = prot_wr && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      idle_cnt <= '0;
    end else if (key_wr) begin
      unlocked <= (bus_wdata == MAGIC);
      idle_cnt <= '0;
    end else if (unlocked) begin
      if (prot_wr)
        idle_cnt <= '0;
      else if (idle_tick) begin
        if (idle_cnt == LAST) begin
          unlocked <= 1'b0;
          idle_cnt <= '0;
        end else
          idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R2
  magic_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && bus_wdata == MAGIC |=> unlocked);
  // R3
  bad_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && bus_wdata != MAGIC |=> !unlocked);
  // R2
  rise_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr));
  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(key_wr || idle_tick));
  // R5
  prot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr && unlocked && !key_wr |=> idle_cnt == '0 && unlocked);
  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_tick && !bus_we |=> $stable(idle_cnt) && $stable(unlocked));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < CW'(IDLE_TICKS));
endmodule

// File: tb/key_write_guard_tb.sv
module key_write_guard_tb_top;
  localparam logic [11:0] KADDR = 12'h00C;
  localparam logic [11:0] LO = 12'h800;
  localparam logic [11:0] HI = 12'h814;
  localparam logic [31:0] MAGIC = 32'hC5AF6927;

  logic clk = 0, rst_n = 0, we = 0, tick = 0;
  logic [11:0] addr = 0;
  logic [31:0] data = 0;
  logic unl, perm;

  int checks = 0, failures = 0;
  bit m_unl = 0;
  int m_idle = 0;
  bit done = 0;

  always #5 clk = ~clk;

  key_write_guard dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(data),
    .bus_we(we), .idle_tick(tick), .unlocked(unl), .wr_permit(perm));

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic t);
    bit ip;
    @(negedge clk);
    we = w; addr = a; data = d; tick = t;
    #1;
    ip = (a >= LO) && (a <= HI);
    chk(tag, unl, m_unl, "unlocked");
    chk(tag, perm, w && ip && m_unl, "wr_permit");
    @(posedge clk);
    if (w && a == KADDR) begin
      m_unl = (d == MAGIC); m_idle = 0;
    end else if (m_unl) begin
      if (w && ip) m_idle = 0;
      else if (t) begin
        m_idle++;
        if (m_idle == 32) begin m_unl = 0; m_idle = 0; end
      end
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0);
  endtask

  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(tag, 0, 0, 0, 1);
      cyc(tag, 0, 0, 0, 0);
    end
  endtask

  task automatic expect_unl(input string tag, input logic e);
    @(negedge clk); #1;
    chk(tag, unl, e, "unlocked(direct)");
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1", unl, 0, "unlocked at reset");
    chk("R1", perm, 0, "wr_permit at reset");
    rst_n = 1;
    idle("R1", 2);
    // R8: locked protected write dropped
    cyc("R8", 1, LO, 32'h1234, 0);
    cyc("R8", 1, HI, 32'h1234, 1);
    expect_unl("R8", 0);
    // R3: near-miss keys keep locked
    cyc("R3", 1, KADDR, MAGIC ^ 32'h8000_0000, 0);
    expect_unl("R3", 0);
    // R2
    cyc("R2", 1, KADDR, MAGIC, 0);
    expect_unl("R2", 1);
    // R7 boundaries
    cyc("R7", 1, LO, 1, 0);
    cyc("R7", 1, HI, 2, 0);
    cyc("R7", 1, LO - 12'd4, 3, 0);
    cyc("R7", 1, HI + 12'd4, 4, 0);
    cyc("R7", 0, LO, 5, 0);
    cyc("R7", 1, 12'h808, 6, 0);
    // R4: 31 ticks stay, 32nd locks
    ticks("R4", 31);
    expect_unl("R4", 1);
    cyc("R4", 0, 0, 0, 1);
    expect_unl("R4", 0);
    // R5: same-cycle tick and protected write
    cyc("R5", 1, KADDR, MAGIC, 0);
    ticks("R5", 20);
    cyc("R5", 1, 12'h810, 7, 1);
    ticks("R5", 31);
    expect_unl("R5", 1);
    cyc("R5", 0, 0, 0, 1);
    expect_unl("R5", 0);
    // R3: zero key and bit-flipped key lock at once
    cyc("R3", 1, KADDR, MAGIC, 0);
    cyc("R3", 1, KADDR, 32'h0, 0);
    expect_unl("R3", 0);
    cyc("R3", 1, KADDR, MAGIC, 0);
    cyc("R3", 1, KADDR, MAGIC ^ 32'h1, 0);
    expect_unl("R3", 0);
    // R6: non-tick cycles and outside writes
    cyc("R6", 1, KADDR, MAGIC, 0);
    ticks("R6", 10);
    idle("R6", 40);
    for (int i = 0; i < 5; i++) cyc("R6", 1, 12'h100 + 12'(i*4), 32'hAA, 0);
    cyc("R6", 1, 12'h200, 32'hBB, 1);
    ticks("R6", 20);
    expect_unl("R6", 1);
    cyc("R6", 0, 0, 0, 1);
    expect_unl("R6", 0);
    // R9: rewrite magic restarts count
    cyc("R9", 1, KADDR, MAGIC, 0);
    ticks("R9", 25);
    cyc("R9", 1, KADDR, MAGIC, 1);
    ticks("R9", 31);
    expect_unl("R9", 1);
    cyc("R9", 0, 0, 0, 1);
    expect_unl("R9", 0);
    idle("R1", 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule